// File: doc/BRIEF.md
# Sample clock source selector

This block owns the clock-control byte that a neighbouring latch drives onto the board's clock logic. A host asks for one of two things: a fixed internal sample rate, given in hertz, or one of three external sync sources. The block turns the request into the byte encoding and keeps every bit that has nothing to do with clocking as it was. The host can also load the whole byte directly. That direct load is the only path by which the upper routing bits change, and it can also produce encodings that no request would ever create.

The block decodes the byte it holds on every cycle. It reports whether the clock is mastered externally, which internal rate the three-bit field selects, and which external source is chosen. It raises a flag when the external encoding matches none of the legal ones. A one-cycle strobe tells the downstream latch to capture the byte each time its value changes. An unsupported request leaves the byte as it was and raises a one-cycle error pulse.

Top module: `clksel_ctrl`

## Requirements
- R1: After a synchronous reset, `cfg_q` is 0x00, which selects internal 44100 Hz with all other bits clear. `is_ext` is 0, `int_rate_hz` is 44100 and `ext_type` is 0. `cfg_wr` is high for exactly the first cycle after reset ends.
- R2: An internal request maps rates to codes in bits 2:0 as follows: 44100→0, 48000→1, 88200→2, 96000→3, 176400→4, 192000→5.
- R3: An accepted internal request writes the code into bits 2:0 and clears bit 3, the sync select bit, where 1 means external. Bit 4 and bits 7:5 keep their values.
- R4: An external request first clears bits 2:0 and bit 4, then applies the source code. Source 0 (S/PDIF) sets bit 3 only. Source 1 (word clock 1x) sets bits 3 and 1. Source 2 (word clock 256x) sets bits 3, 1 and 4, where bit 4 is the 256x select.
- R5: The status outputs follow the byte and update in the same cycle as `cfg_q`. `is_ext` equals bit 3. `ext_type` is 1, 2 or 3 for the three legal external encodings of bits 4:0 (0x08, 0x0A, 0x1A), and 0 otherwise.
- R6: `ext_undef` is 1 exactly when bit 3 is set and bits 4:0 hold none of the three legal external encodings.
- R7: `int_rate_hz` gives the rate for codes 0 to 5 when bit 3 is 0. It reads 0 when bit 3 is 1 or when the code is 6 or 7.
- R8: Clock requests never change bits 7:5 (coax output source, input 1/2 select, input 3/4 select).
- R9: A request for a rate not in the R2 table, or for external source code 3, leaves `cfg_q` unchanged. It raises `req_err` for exactly one cycle.
- R10: `cfg_wr` is high for one cycle after every edge at which `cfg_q` changes value. An accepted request that leaves the value the same raises no strobe.
- R11: A direct load (`load_en`) replaces the whole byte with `load_byte`. When it coincides with a request, the load wins and the request is dropped without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Clock request strobe |
| req_ext | input | 1 | 0: internal rate request, 1: external source request |
| req_hz | input | HZ_W | Requested internal rate in Hz |
| req_src | input | 2 | External source: 0 S/PDIF, 1 word clock 1x, 2 word clock 256x |
| load_en | input | 1 | Direct load of the whole byte |
| load_byte | input | 8 | Byte for the direct load |
| cfg_q | output | 8 | Clock-control byte for the latch |
| cfg_wr | output | 1 | One-cycle capture strobe for the latch |
| is_ext | output | 1 | External mastering |
| int_rate_hz | output | HZ_W | Decoded internal rate, 0 if none |
| ext_type | output | 2 | 0 none, 1 S/PDIF, 2 word clock 1x, 3 word clock 256x |
| ext_undef | output | 1 | Illegal external encoding |
| req_err | output | 1 | One-cycle pulse on an unsupported request |

## Verification
The bench builds the block with the default HZ_W of 18. That width is the smallest that holds 192000, so the bench can send both every legal rate and near misses such as 192001 and the all-ones value 262143. Direct loads make it possible to place illegal encodings in the byte, such as an external bit with a stray rate code, or internal codes 6 and 7. This exercises the undefined flag and the zero-rate decode, which requests alone never reach. It also makes it possible to set the routing bits and confirm that they survive every kind of request.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  localparam int CFG_W   = 8;
  localparam int CODE_W  = 3;
  localparam int N_RATES = 6;

  typedef enum logic [1:0] {
    EXT_NONE  = 2'd0,
    EXT_SPDIF = 2'd1,
    EXT_WC1X  = 2'd2,
    EXT_WC256 = 2'd3
  } ext_kind_e;

  // bits 4:0 patterns for the legal external sources
  localparam logic [4:0] PAT_SPDIF = 5'b01000;
  localparam logic [4:0] PAT_WC1X  = 5'b01010;
  localparam logic [4:0] PAT_WC256 = 5'b11010;

  function automatic int unsigned rate_of_code(input int unsigned code);
    case (code)
      0: return 44100;
      1: return 48000;
      2: return 88200;
      3: return 96000;
      4: return 176400;
      5: return 192000;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/clksel_rate_enc.sv
module clksel_rate_enc
  import clksel_pkg::*;
#(
  parameter int HZ_W = 18
) (
  input  logic [HZ_W-1:0]   hz,
  output logic [CODE_W-1:0] code,
  output logic              hit
);

  logic [N_RATES-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < N_RATES; gi++) begin : g_cmp
      localparam logic [HZ_W-1:0] RATE_C = HZ_W'(rate_of_code(gi));
      assign match[gi] = (hz == RATE_C);
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < N_RATES; i++) begin
      if (match[i]) code = CODE_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/clksel_status.sv
module clksel_status
  import clksel_pkg::*;
#(
  parameter int HZ_W = 18
) (
  input  logic [4:0]      clk_bits,
  output logic            ext,
  output logic [HZ_W-1:0] rate_hz,
  output logic [1:0]      kind,
  output logic            undef
);

  always_comb begin
    ext     = clk_bits[3];
    rate_hz = '0;
    kind    = EXT_NONE;
    undef   = 1'b0;
    if (!clk_bits[3]) begin
      rate_hz = HZ_W'(rate_of_code(32'(clk_bits[2:0])));
    end else begin
      case (clk_bits)
        PAT_SPDIF: kind = EXT_SPDIF;
        PAT_WC1X:  kind = EXT_WC1X;
        PAT_WC256: kind = EXT_WC256;
        default:   undef = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int HZ_W = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_ext,
  input  logic [HZ_W-1:0] req_hz,
  input  logic [1:0]      req_src,
  input  logic            load_en,
  input  logic [7:0]      load_byte,
  output logic [7:0]      cfg_q,
  output logic            cfg_wr,
  output logic            is_ext,
  output logic [HZ_W-1:0] int_rate_hz,
  output logic [1:0]      ext_type,
  output logic            ext_undef,
  output logic            req_err
);

  logic [CODE_W-1:0] enc_code;
  logic              enc_hit;
  logic [CFG_W-1:0]  cfg_n;
  logic              err_n;
  logic              init_pend;
  logic              st_ext, st_undef;
  logic [HZ_W-1:0]   st_rate;
  logic [1:0]        st_kind;

  clksel_rate_enc #(.HZ_W(HZ_W)) u_enc (
    .hz   (req_hz),
    .code (enc_code),
    .hit  (enc_hit)
  );

  // next-byte selection: direct load beats a request
  always_comb begin
    cfg_n = cfg_q;
    err_n = 1'b0;
    if (load_en) begin
      cfg_n = load_byte;
    end else if (req_valid) begin
      if (!req_ext) begin
        if (enc_hit) cfg_n = {cfg_q[7:4], 1'b0, enc_code};
        else         err_n = 1'b1;
      end else begin
        case (req_src)
          2'd0:    cfg_n = {cfg_q[7:5], PAT_SPDIF};
          2'd1:    cfg_n = {cfg_q[7:5], PAT_WC1X};
          2'd2:    cfg_n = {cfg_q[7:5], PAT_WC256};
          default: err_n = 1'b1;
        endcase
      end
    end
  end

  clksel_status #(.HZ_W(HZ_W)) u_stat (
    .clk_bits (cfg_n[4:0]),
    .ext      (st_ext),
    .rate_hz  (st_rate),
    .kind     (st_kind),
    .undef    (st_undef)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      cfg_wr      <= 1'b0;
      init_pend   <= 1'b1;
      req_err     <= 1'b0;
      is_ext      <= 1'b0;
      int_rate_hz <= HZ_W'(rate_of_code(0));
      ext_type    <= EXT_NONE;
      ext_undef   <= 1'b0;
    end else begin
      cfg_q       <= cfg_n;
      cfg_wr      <= init_pend | (cfg_n != cfg_q);
      init_pend   <= 1'b0;
      req_err     <= err_n;
      is_ext      <= st_ext;
      int_rate_hz <= st_rate;
      ext_type    <= st_kind;
      ext_undef   <= st_undef;
    end
  end

  AST_INT_CLEARS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ext && enc_hit && !load_en) |=> (!cfg_q[3] && cfg_q[2:0] == $past(enc_code))); // R3

  AST_ROUTING_KEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !load_en) |=> (cfg_q[7:5] == $past(cfg_q[7:5]))); // R8

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    req_err |-> $stable(cfg_q)); // R9

  AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_q != $past(cfg_q)) |-> cfg_wr); // R10

  AST_UNDEF_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
    ext_undef |-> (is_ext && ext_type == EXT_NONE)); // R6

  AST_EXT_MATCHES_BIT: assert property (@(posedge clk) disable iff (rst)
    is_ext == cfg_q[3]); // R5

endmodule

// File: tb/sim_clksel_ctrl.sv
module sim_clksel_ctrl;

  localparam int HZ_W = 18;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ext = 1'b0;
  logic [HZ_W-1:0] req_hz = '0;
  logic [1:0]      req_src = '0;
  logic            load_en = 1'b0;
  logic [7:0]      load_byte = '0;
  logic [7:0]      cfg_q;
  logic            cfg_wr;
  logic            is_ext;
  logic [HZ_W-1:0] int_rate_hz;
  logic [1:0]      ext_type;
  logic            ext_undef;
  logic            req_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clksel_ctrl #(.HZ_W(HZ_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ext(req_ext),
    .req_hz(req_hz), .req_src(req_src), .load_en(load_en), .load_byte(load_byte),
    .cfg_q(cfg_q), .cfg_wr(cfg_wr), .is_ext(is_ext), .int_rate_hz(int_rate_hz),
    .ext_type(ext_type), .ext_undef(ext_undef), .req_err(req_err)
  );

  function automatic int exp_rate(input int code);
    int tab [6] = '{44100, 48000, 88200, 96000, 176400, 192000};
    return (code < 6) ? tab[code] : 0;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  // drive for one edge, then sample at the following negedge
  task automatic send(input bit ext, input int hz, input int src);
    @(negedge clk);
    req_valid = 1'b1; req_ext = ext; req_hz = HZ_W'(hz); req_src = 2'(src);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load(input int b);
    @(negedge clk);
    load_en = 1'b1; load_byte = 8'(b);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "cfg_q", cfg_q, 8'h00);
    chk("R1", "cfg_wr first", cfg_wr, 1);
    chk("R1", "rate", int_rate_hz, 44100);
    chk("R1", "is_ext", is_ext, 0);
    chk("R1", "ext_type", ext_type, 0);
    @(negedge clk);
    chk("R1", "cfg_wr second", cfg_wr, 0);
  endtask

  task automatic t_rates;
    int codes [6] = '{5, 2, 4, 1, 3, 0};
    foreach (codes[i]) begin
      send(1'b0, exp_rate(codes[i]), 0);
      chk("R2", "code", cfg_q, codes[i]);
      chk("R7", "rate", int_rate_hz, exp_rate(codes[i]));
      chk("R10", "strobe", cfg_wr, 1);
    end
  endtask

  task automatic t_external;
    send(1'b1, 0, 2);
    chk("R4", "wc256", cfg_q, 8'h1A);
    chk("R5", "type wc256", ext_type, 3);
    chk("R5", "is_ext", is_ext, 1);
    chk("R7", "rate while ext", int_rate_hz, 0);
    send(1'b0, 48000, 0);
    chk("R3", "bit4 kept", cfg_q, 8'h11);
    chk("R7", "rate", int_rate_hz, 48000);
    send(1'b1, 0, 0);
    chk("R4", "spdif", cfg_q, 8'h08);
    chk("R5", "type spdif", ext_type, 1);
    send(1'b1, 0, 1);
    chk("R4", "wc1x", cfg_q, 8'h0A);
    chk("R5", "type wc1x", ext_type, 2);
    chk("R6", "undef", ext_undef, 0);
  endtask

  task automatic t_routing;
    load(8'hE3);
    chk("R11", "load", cfg_q, 8'hE3);
    send(1'b1, 0, 2);
    chk("R8", "ext keeps 7:5", cfg_q, 8'hFA);
    send(1'b0, 88200, 0);
    chk("R8", "int keeps 7:5", cfg_q, 8'hF2);
    load(8'hA0);
    send(1'b1, 0, 0);
    chk("R8", "spdif keeps 7:5", cfg_q, 8'hA8);
  endtask

  task automatic t_errors;
    load(8'h03);
    send(1'b0, 192001, 0);
    chk("R9", "bad rate hold", cfg_q, 8'h03);
    chk("R9", "err pulse", req_err, 1);
    chk("R10", "no strobe", cfg_wr, 0);
    @(negedge clk);
    chk("R9", "err one cycle", req_err, 0);
    send(1'b0, 262143, 0);
    chk("R9", "all-ones rate", req_err, 1);
    send(1'b1, 0, 3);
    chk("R9", "src3 hold", cfg_q, 8'h03);
    chk("R9", "src3 err", req_err, 1);
  endtask

  task automatic t_same_value;
    send(1'b0, 96000, 0);
    chk("R10", "same value", cfg_q, 8'h03);
    chk("R10", "no strobe same", cfg_wr, 0);
    chk("R9", "no err", req_err, 0);
  endtask

  task automatic t_decode;
    load(8'h0C);
    chk("R6", "undef ext", ext_undef, 1);
    chk("R5", "type none", ext_type, 0);
    chk("R5", "is_ext", is_ext, 1);
    load(8'h18);
    chk("R6", "undef 256 w/o wc", ext_undef, 1);
    load(8'h06);
    chk("R7", "code6 rate", int_rate_hz, 0);
    chk("R6", "code6 not undef", ext_undef, 0);
    load(8'h05);
    chk("R7", "code5 rate", int_rate_hz, 192000);
  endtask

  task automatic t_priority;
    @(negedge clk);
    load_en = 1'b1; load_byte = 8'h40;
    req_valid = 1'b1; req_ext = 1'b1; req_src = 2'd3;
    @(negedge clk);
    load_en = 1'b0; req_valid = 1'b0;
    chk("R11", "load wins", cfg_q, 8'h40);
    chk("R11", "no err", req_err, 0);
    chk("R10", "strobe", cfg_wr, 1);
  endtask

  initial begin
    t_reset();
    t_rates();
    t_external();
    t_routing();
    t_errors();
    t_same_value();
    t_decode();
    t_priority();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule